// File: doc/BRIEF.md
# Prefetch-Aware Coherent L1 Line Controller

This block runs the coherence state of one line slot in a private first-level cache that takes part in a two-level MESI protocol. Two request queues feed it. The demand queue carries loads, stores and instruction fetches. The prefetch queue carries speculative versions of the same three operations. The line can sit in one of five stable states (not present, invalid, shared, exclusive, modified). It can also sit in one of ten transient states that wait for the second level to answer. The data array, the second-level directory and the network are reduced to a request port and a response port. Only one line slot is modelled, so no tag lookup across several lines takes place.

Each line carries a flag that marks data brought in by a prefetch and not yet used by a demand access. The first demand hit on a flagged line sends a one-cycle hit pulse to an external prefetcher and clears the flag. A demand instruction fetch that finds a prefetch fill that was invalidated in flight sends a one-cycle miss pulse. A request whose address differs from the resident line forces a replacement. If the victim cannot be evicted yet, the block stalls the queue that caused the replacement and no other queue. The stall lasts until the line settles into a stable state, which the block signals with a wake-up pulse.

Top module: `pfl1_line_ctrl`

## Requirements
- R1: After a synchronous active-low reset the line is not present, both stall outputs are low, and with idle inputs every pulse output, pop output and the request valid are low.
- R2: A demand load (kind 0) or instruction fetch (kind 1) to a line that is not present or invalid pops the demand queue and issues a shared read (type 0) for that address. A demand store (kind 2) issues an exclusive read (type 1). Kind 3 acts as a load. For a read-shared miss, shared data (response 0) leads to the shared state and exclusive data (response 1) leads to the exclusive state. Either data response to an exclusive read leads to modified.
- R3: A prefetch to a line that is not present or invalid pops the prefetch queue and issues type 0 for a load or fetch, or type 1 for a store. When that fill completes, the line is marked as prefetched and unused.
- R4: A demand hit (load or fetch in shared, exclusive or modified; store in exclusive or modified) pops the demand queue and issues no request. If the line is marked prefetched, the hit pulses the prefetch-hit output with the line address and clears the mark, so a later hit gives no pulse.
- R5: A store hit in exclusive moves the line to modified, and a store hit in modified stays in modified. A store in shared pops the queue, issues an upgrade (type 2) and waits. Data then moves the line to modified.
- R6: A prefetch whose address matches a line in any state other than not present or invalid is dropped. It pops the prefetch queue, issues no request and leaves the state unchanged.
- R7: A request whose address differs from a line that sits in a transient state stalls only the queue that carried the request. That queue's stall output rises on the next cycle and nothing is popped.
- R8: A request whose address differs from a stable line replaces it the same way for either queue, and pops nothing. Invalid becomes not present. Shared becomes invalid and pulses the eviction output with the old address. Exclusive or modified pulses the eviction output, issues a writeback (type 3) with the old address, and waits for a writeback acknowledge (response 2).
- R9: A demand instruction fetch that finds an invalidated in-flight prefetch fill pulses the prefetch-miss output with the address and pops the demand queue. It issues no request, and the line continues as an invalidated demand fill.
- R10: An invalidate (response 3) sends shared to invalid. It marks an in-flight read-shared fill, demand or prefetch, as invalidated, and the data that then arrives leaves the line invalid. It turns a pending upgrade into an exclusive read. During a writeback it moves the line to a sink state that still waits for the acknowledge.
- R11: Every move from a transient state to a stable state pulses the wake-up output and clears both stall outputs, after which the stalled request is retried.
- R12: A response takes priority over both queues in the same cycle. A demand request takes priority over a prefetch request.
- R13: A demand request that matches a line in a transient state stalls the demand queue, except the fetch case of R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dm_valid_i | input | 1 | Demand queue head is valid |
| dm_kind_i | input | 2 | Demand kind: 0 load, 1 fetch, 2 store |
| dm_addr_i | input | ADDR_W | Demand line address |
| dm_pop_o | output | 1 | Demand head consumed this cycle |
| dm_stall_o | output | 1 | Demand queue parked until wake-up |
| pf_valid_i | input | 1 | Prefetch queue head is valid |
| pf_kind_i | input | 2 | Prefetch kind, same coding |
| pf_addr_i | input | ADDR_W | Prefetch line address |
| pf_pop_o | output | 1 | Prefetch head consumed this cycle |
| pf_stall_o | output | 1 | Prefetch queue parked until wake-up |
| l2_req_valid_o | output | 1 | Request to second level |
| l2_req_type_o | output | 2 | 0 shared read, 1 exclusive read, 2 upgrade, 3 writeback |
| l2_req_addr_o | output | ADDR_W | Request line address |
| l2_rsp_valid_i | input | 1 | Response from second level |
| l2_rsp_type_i | input | 2 | 0 shared data, 1 exclusive data, 2 writeback ack, 3 invalidate |
| pf_hit_o | output | 1 | First demand use of a prefetched line |
| pf_miss_o | output | 1 | Demand fetch found a lost prefetch fill |
| pf_note_addr_o | output | ADDR_W | Address for the hit or miss pulse |
| evict_o | output | 1 | Eviction notice to the core |
| evict_addr_o | output | ADDR_W | Address of the evicted line |
| wake_o | output | 1 | Line left its transient state |

## Verification
The bench builds the block with ADDR_W = 6. With addresses this narrow, the bench can sweep every request kind against both requesters, both fill types and two distinct tags, and predict each outcome arithmetically. It drives each stable victim state through a replacement from each queue in turn, with and without an invalidate in the middle of the writeback. Separate sequences cover the in-flight invalidation paths, the stall and retry round trip, and the priority between a response, the demand queue and the prefetch queue.

// File: rtl/pfl1_pkg.sv
// Package: shared encodings for the prefetch-aware L1 line controller.
// Assumes: two-bit kind, request and response codes as listed in the brief.
package pfl1_pkg;

    typedef enum logic [3:0] {
        ST_NP         = 4'd0,
        ST_I          = 4'd1,
        ST_S          = 4'd2,
        ST_E          = 4'd3,
        ST_M          = 4'd4,
        ST_I2S        = 4'd5,
        ST_I2M        = 4'd6,
        ST_S2M        = 4'd7,
        ST_I2S_INV    = 4'd8,
        ST_M2I        = 4'd9,
        ST_WB_SINK    = 4'd10,
        ST_PF_I2S     = 4'd11,
        ST_PF_I2S_INV = 4'd12,
        ST_PF_I2M     = 4'd13,
        ST_PF_S2M     = 4'd14
    } line_st_e;

    typedef enum logic [1:0] {
        RQ_LOAD   = 2'd0,
        RQ_IFETCH = 2'd1,
        RQ_STORE  = 2'd2,
        RQ_RSVD   = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        L2_GETS = 2'd0,
        L2_GETX = 2'd1,
        L2_UPGR = 2'd2,
        L2_PUTX = 2'd3
    } l2_req_e;

    typedef enum logic [1:0] {
        RS_DATA_SH = 2'd0,
        RS_DATA_EX = 2'd1,
        RS_WB_ACK  = 2'd2,
        RS_INV     = 2'd3
    } l2_rsp_e;

    // True for every state that waits on the second level.
    function automatic logic st_transient(line_st_e s);
        case (s)
            ST_NP, ST_I, ST_S, ST_E, ST_M: return 1'b0;
            default:                       return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/pfl1_req_arb.sv
// Module: picks the request the line controller handles this cycle.
// Assumes: a response in the same cycle blocks both queues; the demand
// queue wins over the prefetch queue; a parked queue is skipped.
module pfl1_req_arb #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic              dm_valid,
    input  logic [1:0]        dm_kind,
    input  logic [ADDR_W-1:0] dm_addr,
    input  logic              dm_blocked,
    input  logic              pf_valid,
    input  logic [1:0]        pf_kind,
    input  logic [ADDR_W-1:0] pf_addr,
    input  logic              pf_blocked,
    output logic              sel_valid,
    output logic              sel_pf,
    output logic [1:0]        sel_kind,
    output logic [ADDR_W-1:0] sel_addr
);

    // Fixed-priority selection: response, then demand, then prefetch.
    always_comb begin
        sel_valid = 1'b0;
        sel_pf    = 1'b0;
        sel_kind  = dm_kind;
        sel_addr  = dm_addr;
        if (!rsp_valid) begin
            if (dm_valid && !dm_blocked) begin
                sel_valid = 1'b1;
            end else if (pf_valid && !pf_blocked) begin
                sel_valid = 1'b1;
                sel_pf    = 1'b1;
                sel_kind  = pf_kind;
                sel_addr  = pf_addr;
            end
        end
    end

    // R12: an eligible demand request is never passed over for a prefetch.
    p_demand_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dm_valid && !dm_blocked && sel_valid) |-> !sel_pf);

    // R12: nothing is selected while a response is being handled.
    p_rsp_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !sel_valid);

endmodule

// File: rtl/pfl1_stall_ctl.sv
// Module: holds one parked flag per input queue.
// Assumes: a stall request and a wake-up never occur in the same cycle,
// because stalls come from requests and wake-ups from responses.
module pfl1_stall_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic stall_dm_set,
    input  logic stall_pf_set,
    input  logic wake,
    output logic dm_blocked,
    output logic pf_blocked
);

    // Set a queue's flag on its stall, clear both on wake-up.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_blocked <= 1'b0;
            pf_blocked <= 1'b0;
        end else if (wake) begin
            dm_blocked <= 1'b0;
            pf_blocked <= 1'b0;
        end else begin
            dm_blocked <= dm_blocked | stall_dm_set;
            pf_blocked <= pf_blocked | stall_pf_set;
        end
    end

    // R7: one replacement never parks both queues at once.
    p_single_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall_dm_set && stall_pf_set));

    // R11: a wake-up releases both queues on the next cycle.
    p_wake_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake |=> (!dm_blocked && !pf_blocked));

endmodule

// File: rtl/pfl1_line_fsm.sv
// Module: coherence state, tag and prefetched-unused mark of one line.
// Assumes: at most one event (a response or one selected request) per
// cycle; every output except the state registers is a same-cycle decode.
module pfl1_line_fsm
    import pfl1_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_type,
    input  logic              sel_valid,
    input  logic              sel_pf,
    input  logic [1:0]        sel_kind,
    input  logic [ADDR_W-1:0] sel_addr,
    output logic              dm_pop,
    output logic              pf_pop,
    output logic              req_valid,
    output logic [1:0]        req_type,
    output logic [ADDR_W-1:0] req_addr,
    output logic              pf_hit,
    output logic              pf_miss,
    output logic              evict,
    output logic [ADDR_W-1:0] evict_addr,
    output logic              stall_dm_set,
    output logic              stall_pf_set,
    output logic              wake
);

    line_st_e          st_q, st_d;
    logic [ADDR_W-1:0] tag_q, tag_d;
    logic              flag_q, flag_d;
    logic              is_data, is_store, tag_match;

    assign is_data    = (rsp_type == RS_DATA_SH) || (rsp_type == RS_DATA_EX);
    assign is_store   = (sel_kind == RQ_STORE);
    assign tag_match  = (st_q == ST_NP) || (sel_addr == tag_q);
    assign evict_addr = tag_q;

    // Next-state and action decode for the current event.
    always_comb begin
        st_d         = st_q;
        tag_d        = tag_q;
        flag_d       = flag_q;
        dm_pop       = 1'b0;
        pf_pop       = 1'b0;
        req_valid    = 1'b0;
        req_type     = L2_GETS;
        req_addr     = sel_addr;
        pf_hit       = 1'b0;
        pf_miss      = 1'b0;
        evict        = 1'b0;
        stall_dm_set = 1'b0;
        stall_pf_set = 1'b0;
        if (rsp_valid) begin
            case (st_q)
                ST_I2S, ST_PF_I2S: begin
                    if (is_data) begin
                        st_d   = (rsp_type == RS_DATA_SH) ? ST_S : ST_E;
                        flag_d = (st_q == ST_PF_I2S);
                    end else if (rsp_type == RS_INV) begin
                        st_d = (st_q == ST_I2S) ? ST_I2S_INV : ST_PF_I2S_INV;
                    end
                end
                ST_I2M, ST_PF_I2M, ST_S2M, ST_PF_S2M: begin
                    if (is_data) begin
                        st_d   = ST_M;
                        flag_d = (st_q == ST_PF_I2M || st_q == ST_PF_S2M) ? 1'b1 : flag_q;
                    end else if (rsp_type == RS_INV && st_q == ST_S2M) begin
                        st_d   = ST_I2M;
                        flag_d = 1'b0;
                    end else if (rsp_type == RS_INV && st_q == ST_PF_S2M) begin
                        st_d   = ST_PF_I2M;
                        flag_d = 1'b0;
                    end
                end
                ST_I2S_INV, ST_PF_I2S_INV: begin
                    if (is_data) begin
                        st_d   = ST_I;
                        flag_d = 1'b0;
                    end
                end
                ST_M2I: begin
                    if (rsp_type == RS_WB_ACK) st_d = ST_I;
                    else if (rsp_type == RS_INV) st_d = ST_WB_SINK;
                end
                ST_WB_SINK: begin
                    if (rsp_type == RS_WB_ACK) st_d = ST_I;
                end
                ST_S: begin
                    if (rsp_type == RS_INV) begin
                        st_d   = ST_I;
                        flag_d = 1'b0;
                    end
                end
                default: ;
            endcase
        end else if (sel_valid) begin
            if (!tag_match) begin
                // Replacement of the resident line.
                flag_d = 1'b0;
                if (st_transient(st_q)) begin
                    flag_d       = flag_q;
                    stall_pf_set = sel_pf;
                    stall_dm_set = !sel_pf;
                end else begin
                    case (st_q)
                        ST_I: st_d = ST_NP;
                        ST_S: begin
                            st_d  = ST_I;
                            evict = 1'b1;
                        end
                        ST_E, ST_M: begin
                            st_d      = ST_M2I;
                            evict     = 1'b1;
                            req_valid = 1'b1;
                            req_type  = L2_PUTX;
                            req_addr  = tag_q;
                        end
                        default: ;
                    endcase
                end
            end else if (sel_pf) begin
                // Prefetch: fetch into an empty line, otherwise drop.
                pf_pop = 1'b1;
                if (st_q == ST_NP || st_q == ST_I) begin
                    tag_d     = sel_addr;
                    flag_d    = 1'b0;
                    req_valid = 1'b1;
                    req_type  = is_store ? L2_GETX : L2_GETS;
                    st_d      = is_store ? ST_PF_I2M : ST_PF_I2S;
                end
            end else begin
                // Demand access to the resident (or empty) line.
                case (st_q)
                    ST_NP, ST_I: begin
                        dm_pop    = 1'b1;
                        tag_d     = sel_addr;
                        flag_d    = 1'b0;
                        req_valid = 1'b1;
                        req_type  = is_store ? L2_GETX : L2_GETS;
                        st_d      = is_store ? ST_I2M : ST_I2S;
                    end
                    ST_S: begin
                        dm_pop = 1'b1;
                        if (is_store) begin
                            req_valid = 1'b1;
                            req_type  = L2_UPGR;
                            st_d      = ST_S2M;
                        end else begin
                            pf_hit = flag_q;
                            flag_d = 1'b0;
                        end
                    end
                    ST_E, ST_M: begin
                        dm_pop = 1'b1;
                        pf_hit = flag_q;
                        flag_d = 1'b0;
                        if (is_store) st_d = ST_M;
                    end
                    ST_PF_I2S_INV: begin
                        if (sel_kind == RQ_IFETCH) begin
                            dm_pop  = 1'b1;
                            pf_miss = 1'b1;
                            st_d    = ST_I2S_INV;
                        end else begin
                            stall_dm_set = 1'b1;
                        end
                    end
                    default: stall_dm_set = 1'b1;
                endcase
            end
        end
    end

    assign wake = st_transient(st_q) && !st_transient(st_d);

    // Line registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_NP;
            tag_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            flag_q <= flag_d;
        end
    end

    // R3: a completed prefetch fill leaves the line marked.
    p_fill_marks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && is_data && (st_q == ST_PF_I2S || st_q == ST_PF_I2M)) |=> flag_q);

    // R4: after a prefetch-hit pulse the mark is gone.
    p_hit_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pf_hit |=> !flag_q);

    // R6: a dropped prefetch leaves the state as it was.
    p_pf_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_pop && st_q != ST_NP && st_q != ST_I) |=> $stable(st_q));

    // R8: a writeback request leaves the line waiting for its acknowledge.
    p_putx_waits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_type == L2_PUTX) |=> (st_q == ST_M2I));

    // R9: a prefetch-miss pulse hands the line over to a demand fill.
    p_ifmiss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_miss |=> (st_q == ST_I2S_INV));

    // R12: only one queue is consumed per cycle.
    p_one_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(dm_pop && pf_pop));

endmodule

// File: rtl/pfl1_line_ctrl.sv
// Module: top of the prefetch-aware L1 line controller.
// Assumes: queue heads stay stable until popped; the second level sends
// at most one response per cycle.
module pfl1_line_ctrl #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dm_valid_i,
    input  logic [1:0]        dm_kind_i,
    input  logic [ADDR_W-1:0] dm_addr_i,
    output logic              dm_pop_o,
    output logic              dm_stall_o,
    input  logic              pf_valid_i,
    input  logic [1:0]        pf_kind_i,
    input  logic [ADDR_W-1:0] pf_addr_i,
    output logic              pf_pop_o,
    output logic              pf_stall_o,
    output logic              l2_req_valid_o,
    output logic [1:0]        l2_req_type_o,
    output logic [ADDR_W-1:0] l2_req_addr_o,
    input  logic              l2_rsp_valid_i,
    input  logic [1:0]        l2_rsp_type_i,
    output logic              pf_hit_o,
    output logic              pf_miss_o,
    output logic [ADDR_W-1:0] pf_note_addr_o,
    output logic              evict_o,
    output logic [ADDR_W-1:0] evict_addr_o,
    output logic              wake_o
);

    logic              sel_valid, sel_pf;
    logic [1:0]        sel_kind;
    logic [ADDR_W-1:0] sel_addr;
    logic              stall_dm_set, stall_pf_set;

    pfl1_req_arb #(.ADDR_W(ADDR_W)) u_arb (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_valid  (l2_rsp_valid_i),
        .dm_valid   (dm_valid_i),
        .dm_kind    (dm_kind_i),
        .dm_addr    (dm_addr_i),
        .dm_blocked (dm_stall_o),
        .pf_valid   (pf_valid_i),
        .pf_kind    (pf_kind_i),
        .pf_addr    (pf_addr_i),
        .pf_blocked (pf_stall_o),
        .sel_valid  (sel_valid),
        .sel_pf     (sel_pf),
        .sel_kind   (sel_kind),
        .sel_addr   (sel_addr)
    );

    pfl1_line_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .rsp_valid    (l2_rsp_valid_i),
        .rsp_type     (l2_rsp_type_i),
        .sel_valid    (sel_valid),
        .sel_pf       (sel_pf),
        .sel_kind     (sel_kind),
        .sel_addr     (sel_addr),
        .dm_pop       (dm_pop_o),
        .pf_pop       (pf_pop_o),
        .req_valid    (l2_req_valid_o),
        .req_type     (l2_req_type_o),
        .req_addr     (l2_req_addr_o),
        .pf_hit       (pf_hit_o),
        .pf_miss      (pf_miss_o),
        .evict        (evict_o),
        .evict_addr   (evict_addr_o),
        .stall_dm_set (stall_dm_set),
        .stall_pf_set (stall_pf_set),
        .wake         (wake_o)
    );

    pfl1_stall_ctl u_stall (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_dm_set (stall_dm_set),
        .stall_pf_set (stall_pf_set),
        .wake         (wake_o),
        .dm_blocked   (dm_stall_o),
        .pf_blocked   (pf_stall_o)
    );

    assign pf_note_addr_o = sel_addr;

    // R9: a prefetch-miss pulse carries a demand-side address.
    p_miss_from_demand_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pf_miss_o |-> (dm_pop_o && pf_note_addr_o == dm_addr_i));

endmodule

// File: tb/pfl1_line_ctrl_tb.sv
`timescale 1ns/1ps
module pfl1_line_ctrl_tb_top;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dm_valid = 1'b0, pf_valid = 1'b0, rsp_valid = 1'b0;
    logic [1:0]    dm_kind = '0, pf_kind = '0, rsp_type = '0;
    logic [AW-1:0] dm_addr = '0, pf_addr = '0;
    logic          dm_pop, dm_stall, pf_pop, pf_stall, req_valid;
    logic [1:0]    req_type;
    logic [AW-1:0] req_addr, note_addr, evict_addr;
    logic          pf_hit, pf_miss, evict, wake;

    pfl1_line_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dm_valid_i(dm_valid), .dm_kind_i(dm_kind), .dm_addr_i(dm_addr),
        .dm_pop_o(dm_pop), .dm_stall_o(dm_stall),
        .pf_valid_i(pf_valid), .pf_kind_i(pf_kind), .pf_addr_i(pf_addr),
        .pf_pop_o(pf_pop), .pf_stall_o(pf_stall),
        .l2_req_valid_o(req_valid), .l2_req_type_o(req_type), .l2_req_addr_o(req_addr),
        .l2_rsp_valid_i(rsp_valid), .l2_rsp_type_i(rsp_type),
        .pf_hit_o(pf_hit), .pf_miss_o(pf_miss), .pf_note_addr_o(note_addr),
        .evict_o(evict), .evict_addr_o(evict_addr), .wake_o(wake)
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // Sampled outputs of the last cycle.
    int s_dpop, s_ppop, s_rv, s_rt, s_ra, s_hit, s_miss, s_na, s_ev, s_ea, s_wake;

    task automatic chk(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: drive after a falling edge, sample before the rising edge.
    task automatic cyc(logic dv, logic [1:0] dk, logic [AW-1:0] da,
                       logic pv, logic [1:0] pk, logic [AW-1:0] pa,
                       logic rv, logic [1:0] rt);
        dm_valid = dv; dm_kind = dk; dm_addr = da;
        pf_valid = pv; pf_kind = pk; pf_addr = pa;
        rsp_valid = rv; rsp_type = rt;
        #5;
        s_dpop = dm_pop;   s_ppop = pf_pop; s_rv = req_valid; s_rt = req_type;
        s_ra = req_addr;   s_hit = pf_hit;  s_miss = pf_miss; s_na = note_addr;
        s_ev = evict;      s_ea = evict_addr; s_wake = wake;
        @(negedge clk);
        dm_valid = 1'b0; pf_valid = 1'b0; rsp_valid = 1'b0;
    endtask

    task automatic dmq(logic [1:0] k, logic [AW-1:0] a); cyc(1, k, a, 0, 0, 0, 0, 0); endtask
    task automatic pfq(logic [1:0] k, logic [AW-1:0] a); cyc(0, 0, 0, 1, k, a, 0, 0); endtask
    task automatic rsp(logic [1:0] t); cyc(0, 0, 0, 0, 0, 0, 1, t); endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        rst_n = 1'b1;
    endtask

    // Bring the line to shared (0), exclusive (1) or modified (2) at address a.
    task automatic bring(int st, logic [AW-1:0] a);
        do_reset();
        dmq((st == 2) ? 2'd2 : 2'd0, a);
        rsp((st == 0) ? 2'd0 : 2'd1);
    endtask

    initial begin
        @(negedge clk);
        // R1: reset state with idle inputs.
        rst_n = 1'b0;
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 pops in reset", s_dpop + s_ppop, 0);
        chk("R1 pulses in reset", s_rv + s_hit + s_miss + s_ev + s_wake, 0);
        rst_n = 1'b1;
        cyc(0, 0, 0, 0, 0, 0, 0, 0);
        chk("R1 stall outputs", dm_stall + pf_stall, 0);
        chk("R1 idle request", s_rv, 0);

        // Sweep: kind x requester x fill type x address (R2 R3 R4 R5).
        for (int k = 0; k < 4; k++) begin
            for (int p = 0; p < 2; p++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int ai = 0; ai < 2; ai++) begin
                        logic [AW-1:0] a;
                        int exp_st;  // 0 S, 1 E, 2 M
                        a = (ai == 0) ? 6'd5 : 6'd42;
                        do_reset();
                        if (p == 1) begin
                            pfq(2'(k), a);
                            chk("R3 prefetch miss pop", s_ppop, 1);
                            chk("R3 no demand pop", s_dpop, 0);
                        end else begin
                            dmq(2'(k), a);
                            chk("R2 demand miss pop", s_dpop, 1);
                        end
                        chk("R2 miss request", s_rv, 1);
                        chk("R2 miss type", s_rt, (k == 2) ? 1 : 0);
                        chk("R2 miss addr", s_ra, int'(a));
                        rsp(2'(f));
                        chk("R11 wake on fill", s_wake, 1);
                        exp_st = (k == 2) ? 2 : f;
                        dmq(2'd0, a);
                        chk("R4 load hit pop", s_dpop, 1);
                        chk("R4 hit no request", s_rv, 0);
                        chk("R4 first hit pulse", s_hit, p);
                        if (p == 1) chk("R4 hit addr", s_na, int'(a));
                        dmq(2'd1, a);
                        chk("R4 second hit silent", s_hit, 0);
                        dmq(2'd2, a);
                        chk("R5 store pop", s_dpop, 1);
                        chk("R4 store no pulse", s_hit, 0);
                        if (exp_st == 0) begin
                            chk("R5 upgrade request", s_rv, 1);
                            chk("R5 upgrade type", s_rt, 2);
                            rsp(2'(f));
                            chk("R5 upgrade done wake", s_wake, 1);
                            dmq(2'd2, a);
                        end
                        chk("R5 store hit in E or M", s_rv, 0);
                        dmq(2'd0, a + 6'd1);
                        chk("R8 modified evict pulse", s_ev, 1);
                        chk("R8 writeback type", s_rt, 3);
                        chk("R8 writeback addr", s_ra, int'(a));
                        chk("R8 no pop on evict", s_dpop, 0);
                    end
                end
            end
        end

        // Replacement of each stable state from each queue (R7 R8 R10 R11).
        for (int st = 0; st < 3; st++) begin
            for (int who = 0; who < 2; who++) begin
                logic [AW-1:0] v, n;
                v = 6'd7;
                n = 6'd20;
                bring(st, v);
                if (who == 0) dmq(2'd0, n); else pfq(2'd0, n);
                chk("R8 evict pulse", s_ev, 1);
                chk("R8 evict addr", s_ea, int'(v));
                chk("R8 replace no pop", s_dpop + s_ppop, 0);
                if (st == 0) begin
                    chk("R8 shared no writeback", s_rv, 0);
                end else begin
                    chk("R8 writeback issued", s_rv, 1);
                    chk("R8 writeback type", s_rt, 3);
                    if (who == 0) dmq(2'd0, n); else pfq(2'd0, n);
                    chk("R7 stall no pop", s_dpop + s_ppop, 0);
                    chk("R7 demand stall flag", dm_stall, (who == 0) ? 1 : 0);
                    chk("R7 prefetch stall flag", pf_stall, (who == 1) ? 1 : 0);
                    if (st == 2) begin
                        rsp(2'd3);
                        chk("R10 inval in writeback no wake", s_wake, 0);
                        chk("R10 still parked", dm_stall + pf_stall, 1);
                    end
                    rsp(2'd2);
                    chk("R11 wake on ack", s_wake, 1);
                    chk("R11 stalls cleared", dm_stall + pf_stall, 0);
                end
                if (who == 0) dmq(2'd0, n); else pfq(2'd0, n);
                chk("R8 invalid dealloc no pop", s_dpop + s_ppop, 0);
                chk("R8 invalid dealloc no evict", s_ev + s_rv, 0);
                if (who == 0) dmq(2'd0, n); else pfq(2'd0, n);
                chk("R11 retried request popped", (who == 0) ? s_dpop : s_ppop, 1);
                chk("R11 retried request addr", s_ra, int'(n));
            end
        end

        // R6: prefetch drops in stable and transient states.
        bring(0, 6'd11);
        for (int k = 0; k < 3; k++) begin
            pfq(2'(k), 6'd11);
            chk("R6 drop pop", s_ppop, 1);
            chk("R6 drop no request", s_rv, 0);
        end
        dmq(2'd2, 6'd11);
        chk("R6 state still shared", s_rt, 2);
        pfq(2'd2, 6'd11);
        chk("R6 drop in upgrade", s_ppop + s_rv, 1);
        rsp(2'd3);
        chk("R10 upgrade inval no wake", s_wake, 0);
        rsp(2'd1);
        chk("R10 exclusive fill wake", s_wake, 1);
        dmq(2'd0, 6'd12);
        chk("R10 line ended modified", s_rt, 3);

        // R9: fetch into an invalidated prefetch fill.
        do_reset();
        pfq(2'd0, 6'd12);
        rsp(2'd3);
        chk("R10 prefetch fill inval no wake", s_wake, 0);
        dmq(2'd1, 6'd12);
        chk("R9 miss pulse", s_miss, 1);
        chk("R9 miss addr", s_na, 12);
        chk("R9 pop", s_dpop, 1);
        chk("R9 no request", s_rv, 0);
        rsp(2'd0);
        chk("R10 data after inval wake", s_wake, 1);
        dmq(2'd0, 6'd12);
        chk("R10 line left invalid", s_rv, 1);
        chk("R10 refetch type", s_rt, 0);

        // R13: demand load into invalidated prefetch fill stalls, then retries.
        do_reset();
        pfq(2'd0, 6'd13);
        rsp(2'd3);
        dmq(2'd0, 6'd13);
        chk("R13 load stalls", s_dpop, 0);
        chk("R13 no miss pulse", s_miss, 0);
        chk("R13 demand parked", dm_stall, 1);
        chk("R13 prefetch not parked", pf_stall, 0);
        rsp(2'd0);
        chk("R11 wake", s_wake, 1);
        dmq(2'd0, 6'd13);
        chk("R11 retry popped", s_dpop, 1);
        chk("R4 invalidated fill no hit", s_hit, 0);

        // R13: demand matching an in-flight demand fill.
        do_reset();
        dmq(2'd0, 6'd30);
        dmq(2'd0, 6'd30);
        chk("R13 matching transient stall", s_dpop + s_rv, 0);
        chk("R13 demand parked", dm_stall, 1);

        // R12: priorities.
        do_reset();
        cyc(1, 2'd0, 6'd30, 1, 2'd0, 6'd31, 0, 0);
        chk("R12 demand wins pop", s_dpop, 1);
        chk("R12 prefetch waits", s_ppop, 0);
        chk("R12 demand addr", s_ra, 30);
        cyc(1, 2'd0, 6'd30, 1, 2'd0, 6'd30, 1, 2'd1);
        chk("R12 response first", s_dpop + s_ppop, 0);
        chk("R12 response handled", s_wake, 1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule